// File: doc/BRIEF.md
# Banked Data Memory Address Mapper

This block sits between an 8-bit microcontroller core and its data space of 256 byte addresses. It turns each access into one of three targets: a location in the special-function register window, a byte in one of several general-purpose RAM banks, or nothing at all. The register window covers addresses 00H to 3FH and is shared by every bank. The RAM covers 40H to FFH and has 192 bytes per bank. The RAM banks are stored inside the block. The register file itself lives outside, and the block reaches it through a select, an address, a write strobe and a read-data return.

Two addresses inside the window are indirection ports. An access to 00H uses the value of pointer 0 as its real address, and an access to 02H uses the value of pointer 1. The bank pointer only matters when the access goes through pointer 1 and lands in RAM. In that case a bank pointer of 01H or 02H selects bank 1 or bank 2, and any other value selects bank 0. All other paths reach bank 0: direct addressing, and every access through pointer 0.

Reads return data one cycle after the request. Writes, bit-set and bit-clear finish in the request cycle. A bit operation does a read-modify-write on the selected byte in a single cycle, whether that byte is in RAM or in the register window. A small controller with two states produces the read response. `ST_IDLE` moves to `ST_RESP` when a read is requested and otherwise stays in `ST_IDLE`. `ST_RESP` goes back to `ST_RESP` on a back-to-back read and otherwise goes to `ST_IDLE`. The read-valid output is high exactly while the controller is in `ST_RESP`.

Top module: `dmem_bank_steer`

## Requirements
- R1: After reset `rd_valid` is 0, `rd_data` is 00H, and `sfr_sel`, `sfr_wr` and `bank_hit` are all 0.
- R2: A read request in one cycle gives `rd_valid` = 1 in the next cycle, with `rd_data` holding the byte that was addressed. A cycle that follows a cycle with no read shows `rd_valid` = 0.
- R3: When the resolved address is in 00H–3FH and is implemented, the access drives `sfr_sel` with `sfr_addr` equal to the low six bits of the resolved address. This does not depend on the bank pointer. A read returns `sfr_rdata`, and the access never touches a RAM bank.
- R4: Location 1FH and locations 30H–3FH are unimplemented. A read of one of them returns 00H, and a write leaves `sfr_sel` and `sfr_wr` low.
- R5: A direct access to 40H–FFH always reaches bank 0 (`bank_hit` = 001b), whatever the bank pointer holds.
- R6: An access at address 02H uses `ptr1_val` as its address. When that address is 40H or above, a bank pointer of 01H reaches bank 1 (`bank_hit` = 010b) and 02H reaches bank 2 (`bank_hit` = 100b). At most one bit of `bank_hit` is ever set.
- R7: An access at address 00H uses `ptr0_val` as its address and always reaches bank 0 in RAM.
- R8: Through pointer 1, a bank pointer other than 00H, 01H or 02H selects bank 0.
- R9: An indirect access whose pointer holds 00H or 02H reads 00H. A write, bit-set or bit-clear of that kind changes nothing: `sfr_wr` and `bank_hit` both stay 0.
- R10: `req_op` = 3 sets and `req_op` = 4 clears bit `req_bit` of the addressed RAM byte in one cycle. The other seven bits are left as they were.
- R11: A bit-set or bit-clear that resolves to an implemented register drives `sfr_wr`. `sfr_wdata` is then `sfr_rdata` with only bit `req_bit` forced to 1 or 0.
- R12: `req_op` encoding: 0 idle, 1 read, 2 write, 3 bit-set, 4 bit-clear. Values 5 to 7 act as idle, with no strobe, no RAM change and no read response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_op | input | 3 | Operation code (see R12) |
| req_addr | input | 8 | Direct address of the request |
| req_wdata | input | 8 | Write data for `req_op` = 2 |
| req_bit | input | 3 | Bit index for set/clear |
| ptr0_val | input | 8 | Current value of pointer 0 |
| ptr1_val | input | 8 | Current value of pointer 1 |
| bank_ptr | input | 8 | Current bank-pointer value |
| sfr_rdata | input | 8 | Read data from the register file at `sfr_addr` |
| sfr_sel | output | 1 | Request targets an implemented register |
| sfr_addr | output | 6 | Register index within the window |
| sfr_wr | output | 1 | Register write strobe |
| sfr_wdata | output | 8 | Register write data |
| bank_hit | output | 3 | One-hot RAM bank touched this cycle |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 8 | Read response data |

## Verification
The bench writes distinct values to the same offset in all three banks and then reads each one back through direct addressing, through pointer 0 and through pointer 1, with the bank pointer at 0, 1, 2, 3 and FFH. A mapper that applied the bank pointer to direct or pointer-0 accesses, or that did not clamp out-of-range bank values, would return a byte from the wrong bank. The bench also points both pointers at the indirection ports themselves. A design without the guard against recursive indirection would raise a strobe or return non-zero data there. Further checks cover the 3FH/40H boundary, the unimplemented hole at 1FH, bit operations that must leave neighbouring bits unchanged, and op codes 5 to 7. These catch off-by-one window decoding, whole-byte writes during set or clear, and spurious responses.

// File: rtl/dm_pkg.sv
package dm_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_BSET  = 3'd3,
        OP_BCLR  = 3'd4
    } dm_op_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SFR  = 2'd1,
        TGT_RAM  = 2'd2
    } dm_tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } dm_state_e;

endpackage

// File: rtl/dm_addr_resolve.sv
module dm_addr_resolve
    import dm_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SFR_SPAN  = 64,
    parameter int NUM_BANKS = 3,
    parameter logic [ADDR_W-1:0]   IND0_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0]   IND1_ADDR = 8'h02,
    parameter logic [SFR_SPAN-1:0] SFR_IMPL  = 64'h0000_FFFF_7FFF_FFFF,
    localparam int SFR_AW    = $clog2(SFR_SPAN),
    localparam int RAM_DEPTH = (1 << ADDR_W) - SFR_SPAN,
    localparam int IDX_W     = $clog2(RAM_DEPTH)
) (
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [ADDR_W-1:0]    ptr0_val,
    input  logic [ADDR_W-1:0]    ptr1_val,
    input  logic [ADDR_W-1:0]    bank_ptr,
    output logic [ADDR_W-1:0]    eff_addr,
    output dm_tgt_e              tgt,
    output logic [NUM_BANKS-1:0] bank_oh,
    output logic [IDX_W-1:0]     ram_idx
);

    logic              use_p0;
    logic              use_p1;
    logic              self_ref;
    logic [ADDR_W-1:0] bank_num;

    always_comb begin
        use_p0   = (req_addr == IND0_ADDR);
        use_p1   = (req_addr == IND1_ADDR);
        eff_addr = use_p0 ? ptr0_val : (use_p1 ? ptr1_val : req_addr);
        // a pointer aimed at either indirection port resolves to nothing
        self_ref = (use_p0 || use_p1) &&
                   ((eff_addr == IND0_ADDR) || (eff_addr == IND1_ADDR));

        if (self_ref) begin
            tgt = TGT_NONE;
        end else if (eff_addr < ADDR_W'(SFR_SPAN)) begin
            tgt = SFR_IMPL[eff_addr[SFR_AW-1:0]] ? TGT_SFR : TGT_NONE;
        end else begin
            tgt = TGT_RAM;
        end

        // only pointer 1 honours the bank pointer; out-of-range falls to bank 0
        if (use_p1 && (bank_ptr < ADDR_W'(NUM_BANKS))) begin
            bank_num = bank_ptr;
        end else begin
            bank_num = '0;
        end

        for (int b = 0; b < NUM_BANKS; b++) begin
            bank_oh[b] = (tgt == TGT_RAM) && (bank_num == ADDR_W'(b));
        end

        ram_idx = IDX_W'(eff_addr - ADDR_W'(SFR_SPAN));
    end

endmodule

// File: rtl/dm_ram_bank.sv
module dm_ram_bank
    import dm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 192,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  dm_op_e            op,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BIT_W-1:0]  bit_idx,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    assign rdata = mem[idx];

    always_ff @(posedge clk) begin
        if (sel) begin
            case (op)
                OP_WRITE: mem[idx] <= wdata;
                OP_BSET:  mem[idx][bit_idx] <= 1'b1;
                OP_BCLR:  mem[idx][bit_idx] <= 1'b0;
                default:  ;
            endcase
        end
    end

    // R10: the indexed bit takes the requested value on the next edge
    assert_bit_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_BSET) |=> mem[$past(idx)][$past(bit_idx)]);

    assert_bit_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && op == OP_BCLR) |=> !mem[$past(idx)][$past(bit_idx)]);

endmodule

// File: rtl/dm_resp_ctrl.sv
module dm_resp_ctrl
    import dm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_src,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    dm_state_e state_q;
    dm_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_src;
    end

    assign rd_valid = (state_q == ST_RESP);

    // R2: a read request is answered exactly one cycle later
    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

endmodule

// File: rtl/dmem_bank_steer.sv
module dmem_bank_steer
    import dm_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SFR_SPAN  = 64,
    parameter int NUM_BANKS = 3,
    parameter logic [ADDR_W-1:0]   IND0_ADDR = 8'h00,
    parameter logic [ADDR_W-1:0]   IND1_ADDR = 8'h02,
    parameter logic [SFR_SPAN-1:0] SFR_IMPL  = 64'h0000_FFFF_7FFF_FFFF,
    localparam int SFR_AW    = $clog2(SFR_SPAN),
    localparam int BIT_W     = $clog2(DATA_W),
    localparam int RAM_DEPTH = (1 << ADDR_W) - SFR_SPAN,
    localparam int IDX_W     = $clog2(RAM_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BIT_W-1:0]     req_bit,
    input  logic [ADDR_W-1:0]    ptr0_val,
    input  logic [ADDR_W-1:0]    ptr1_val,
    input  logic [ADDR_W-1:0]    bank_ptr,
    input  logic [DATA_W-1:0]    sfr_rdata,
    output logic                 sfr_sel,
    output logic [SFR_AW-1:0]    sfr_addr,
    output logic                 sfr_wr,
    output logic [DATA_W-1:0]    sfr_wdata,
    output logic [NUM_BANKS-1:0] bank_hit,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data
);

    dm_op_e                 op;
    logic                   op_live;
    logic                   op_mod;
    logic [ADDR_W-1:0]      eff_addr;
    dm_tgt_e                tgt;
    logic [NUM_BANKS-1:0]   bank_oh;
    logic [IDX_W-1:0]       ram_idx;
    logic [DATA_W-1:0]      bank_rd [NUM_BANKS];
    logic [DATA_W-1:0]      ram_rd;
    logic [DATA_W-1:0]      rd_src;
    logic [DATA_W-1:0]      bit_mask;

    // op code decode; unused codes collapse to idle
    always_comb begin
        case (req_op)
            3'd1:    op = OP_READ;
            3'd2:    op = OP_WRITE;
            3'd3:    op = OP_BSET;
            3'd4:    op = OP_BCLR;
            default: op = OP_IDLE;
        endcase
        op_live = (op != OP_IDLE);
        op_mod  = (op == OP_WRITE) || (op == OP_BSET) || (op == OP_BCLR);
    end

    dm_addr_resolve #(
        .ADDR_W   (ADDR_W),
        .SFR_SPAN (SFR_SPAN),
        .NUM_BANKS(NUM_BANKS),
        .IND0_ADDR(IND0_ADDR),
        .IND1_ADDR(IND1_ADDR),
        .SFR_IMPL (SFR_IMPL)
    ) u_resolve (
        .req_addr(req_addr),
        .ptr0_val(ptr0_val),
        .ptr1_val(ptr1_val),
        .bank_ptr(bank_ptr),
        .eff_addr(eff_addr),
        .tgt     (tgt),
        .bank_oh (bank_oh),
        .ram_idx (ram_idx)
    );

    assign bank_hit = op_live ? bank_oh : '0;

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            dm_ram_bank #(
                .DATA_W(DATA_W),
                .DEPTH (RAM_DEPTH)
            ) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .sel    (bank_hit[g]),
                .op     (op),
                .idx    (ram_idx),
                .wdata  (req_wdata),
                .bit_idx(req_bit),
                .rdata  (bank_rd[g])
            );
        end
    endgenerate

    always_comb begin
        ram_rd = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_oh[b]) ram_rd = ram_rd | bank_rd[b];
        end
    end

    // register window steering, including single-cycle bit modify
    always_comb begin
        bit_mask  = DATA_W'(1) << req_bit;
        sfr_sel   = op_live && (tgt == TGT_SFR);
        sfr_addr  = eff_addr[SFR_AW-1:0];
        sfr_wr    = sfr_sel && op_mod;
        case (op)
            OP_BSET: sfr_wdata = sfr_rdata | bit_mask;
            OP_BCLR: sfr_wdata = sfr_rdata & ~bit_mask;
            default: sfr_wdata = req_wdata;
        endcase
    end

    always_comb begin
        unique case (tgt)
            TGT_SFR: rd_src = sfr_rdata;
            TGT_RAM: rd_src = ram_rd;
            default: rd_src = '0;
        endcase
    end

    dm_resp_ctrl #(
        .DATA_W(DATA_W)
    ) u_resp (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (op == OP_READ),
        .rd_src  (rd_src),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    // R3: a register access never reaches a RAM bank
    assert_sfr_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_sel |-> (bank_hit == '0));

    // R5: direct RAM addresses always land in bank 0
    assert_direct_bank0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_op >= 3'd1) && (req_op <= 3'd4) && (req_addr >= ADDR_W'(SFR_SPAN)))
        |-> (bank_hit == NUM_BANKS'(1)));

    // R6: never more than one bank at a time
    assert_bank_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_hit));

    // R7: pointer 0 ignores the bank pointer
    assert_ptr0_bank0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_op >= 3'd1) && (req_op <= 3'd4) && (req_addr == IND0_ADDR) &&
         (ptr0_val >= ADDR_W'(SFR_SPAN)))
        |-> (bank_hit == NUM_BANKS'(1)));

    // R9: a pointer aimed at an indirection port changes nothing
    assert_self_ref_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((req_addr == IND0_ADDR) && ((ptr0_val == IND0_ADDR) || (ptr0_val == IND1_ADDR))) ||
         ((req_addr == IND1_ADDR) && ((ptr1_val == IND0_ADDR) || (ptr1_val == IND1_ADDR))))
        |-> (!sfr_wr && (bank_hit == '0)));

    // R12: unused op codes are inert
    assert_bad_op_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op > 3'd4) |-> (!sfr_sel && (bank_hit == '0)));

endmodule

// File: tb/test_dmem_bank_steer.sv
module test_dmem_bank_steer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_op = '0;
    logic [7:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic [2:0] req_bit = '0;
    logic [7:0] ptr0_val = '0;
    logic [7:0] ptr1_val = '0;
    logic [7:0] bank_ptr = '0;
    logic [7:0] sfr_rdata;
    logic       sfr_sel;
    logic [5:0] sfr_addr;
    logic       sfr_wr;
    logic [7:0] sfr_wdata;
    logic [2:0] bank_hit;
    logic       rd_valid;
    logic [7:0] rd_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmem_bank_steer i_dmem_bank_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_op   (req_op),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_bit  (req_bit),
        .ptr0_val (ptr0_val),
        .ptr1_val (ptr1_val),
        .bank_ptr (bank_ptr),
        .sfr_rdata(sfr_rdata),
        .sfr_sel  (sfr_sel),
        .sfr_addr (sfr_addr),
        .sfr_wr   (sfr_wr),
        .sfr_wdata(sfr_wdata),
        .bank_hit (bank_hit),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // stand-in register file outside the block
    logic [7:0] sfr_dev [64];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) sfr_dev[i] <= 8'h00;
        end else if (sfr_wr) begin
            sfr_dev[sfr_addr] <= sfr_wdata;
        end
    end
    assign sfr_rdata = sfr_dev[sfr_addr];

    logic [7:0] ram_m [3][192];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    bit         rd_pend = 1'b0;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [7:0] wd,
                         input logic [2:0] b, input logic [7:0] p0, input logic [7:0] p1,
                         input logic [7:0] bp, input string tag);
        int         kind;
        int         bank;
        int         idx;
        logic [7:0] ea;
        logic [7:0] sw;
        logic [7:0] rv;
        bit         via0;
        bit         via1;
        @(negedge clk);
        req_op = op; req_addr = a; req_wdata = wd; req_bit = b;
        ptr0_val = p0; ptr1_val = p1; bank_ptr = bp;
        #1;
        via0 = (a == 8'h00);
        via1 = (a == 8'h02);
        ea   = via0 ? p0 : (via1 ? p1 : a);
        bank = 0;
        if ((via0 || via1) && (ea == 8'h00 || ea == 8'h02)) kind = 0;
        else if (ea < 8'h40) kind = (ea <= 8'h2F && ea != 8'h1F) ? 1 : 0;
        else begin
            kind = 2;
            if (via1 && (bp == 8'h01 || bp == 8'h02)) bank = int'(bp);
        end
        if (op == 3'd0 || op > 3'd4) kind = 0;
        idx = int'(ea) - 64;

        chk({tag, " sfr_sel"}, sfr_sel, (kind == 1));
        if (kind == 1) chk({tag, " sfr_addr"}, sfr_addr, ea[5:0]);
        chk({tag, " sfr_wr"}, sfr_wr, (kind == 1 && op != 3'd1));
        if (kind == 1 && op != 3'd1) begin
            sw = wd;
            if (op == 3'd3) sw = sfr_dev[ea[5:0]] | (8'h01 << b);
            if (op == 3'd4) sw = sfr_dev[ea[5:0]] & ~(8'h01 << b);
            chk({tag, " sfr_wdata"}, sfr_wdata, sw);
        end
        chk({tag, " bank_hit"}, bank_hit, (kind == 2) ? (32'd1 << bank) : 32'd0);

        if (op == 3'd1) begin
            rv = 8'h00;
            if (kind == 1) rv = sfr_dev[ea[5:0]];
            if (kind == 2) rv = ram_m[bank][idx];
            exp_q.push_back(rv);
            tag_q.push_back({tag, " rd_data"});
            rd_pend = 1'b1;
        end
        if (kind == 2) begin
            case (op)
                3'd2: ram_m[bank][idx] = wd;
                3'd3: ram_m[bank][idx][b] = 1'b1;
                3'd4: ram_m[bank][idx][b] = 1'b0;
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_op = 3'd0;
        end
    endtask

    // scoreboard monitor: pops one expected byte per response
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rd_pend) begin
                rd_pend = 1'b0;
                chk("R2 rd_valid latency", rd_valid, 1);
                if (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end else if (rd_valid) begin
                chk("R2 R12 unexpected rd_valid", rd_valid, 0);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_valid", rd_valid, 0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 bank_hit", bank_hit, 0);
        chk("R1 sfr_sel", sfr_sel, 0);
        chk("R1 sfr_wr", sfr_wr, 0);

        // R3 shared register window
        issue(3'd2, 8'h05, 8'hA5, 3'd0, 8'h00, 8'h00, 8'h02, "R3 write 05");
        issue(3'd1, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 8'h01, "R3 read bp1");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'h05, 8'h02, "R3 via ptr1 bp2");
        issue(3'd1, 8'h00, 8'h00, 3'd0, 8'h05, 8'h00, 8'h01, "R3 via ptr0");

        // R4 unimplemented locations
        issue(3'd2, 8'h1F, 8'h77, 3'd0, 8'h00, 8'h00, 8'h00, "R4 write 1F");
        issue(3'd1, 8'h1F, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R4 read 1F");
        issue(3'd2, 8'h3F, 8'h66, 3'd0, 8'h00, 8'h00, 8'h00, "R4 write 3F");
        issue(3'd1, 8'h3F, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R4 read 3F");

        // R5 R6 bank steering
        issue(3'd2, 8'h50, 8'h11, 3'd0, 8'h00, 8'h00, 8'h01, "R5 direct ignores bp");
        issue(3'd2, 8'h02, 8'h22, 3'd0, 8'h00, 8'h50, 8'h01, "R6 write bank1");
        issue(3'd2, 8'h02, 8'h33, 3'd0, 8'h00, 8'h50, 8'h02, "R6 write bank2");
        issue(3'd1, 8'h50, 8'h00, 3'd0, 8'h00, 8'h00, 8'h02, "R5 direct read");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'h50, 8'h01, "R6 read bank1");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'h50, 8'h02, "R6 read bank2");
        issue(3'd2, 8'h40, 8'h5A, 3'd0, 8'h00, 8'h00, 8'h00, "R5 first ram byte");
        issue(3'd2, 8'hFF, 8'hC3, 3'd0, 8'h00, 8'h00, 8'h02, "R5 last ram byte");
        issue(3'd2, 8'h02, 8'h3C, 3'd0, 8'h00, 8'hFF, 8'h02, "R6 last byte bank2");
        issue(3'd1, 8'h40, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R5 read 40");
        issue(3'd1, 8'hFF, 8'h00, 3'd0, 8'h00, 8'h00, 8'h01, "R5 read FF");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h02, "R6 read FF bank2");

        // R7 pointer 0 stays in bank 0
        issue(3'd1, 8'h00, 8'h00, 3'd0, 8'h50, 8'h00, 8'h02, "R7 ptr0 read");
        issue(3'd2, 8'h00, 8'h44, 3'd0, 8'h60, 8'h00, 8'h01, "R7 ptr0 write");
        issue(3'd1, 8'h60, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R7 direct readback");

        // R8 out-of-range bank pointer
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'h50, 8'h03, "R8 bp 03");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'h50, 8'hFF, "R8 bp FF");

        // R9 self-referencing pointers
        issue(3'd2, 8'h02, 8'h99, 3'd0, 8'h00, 8'h02, 8'h01, "R9 ptr1=02 write");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'h00, 8'h01, "R9 ptr1=00 read");
        issue(3'd3, 8'h00, 8'h00, 3'd1, 8'h00, 8'h00, 8'h00, "R9 ptr0=00 bset");
        issue(3'd1, 8'h00, 8'h00, 3'd0, 8'h02, 8'h00, 8'h00, "R9 ptr0=02 read");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'h50, 8'h01, "R9 bank1 unchanged");

        // R10 bit operations on RAM
        issue(3'd2, 8'h80, 8'h0F, 3'd0, 8'h00, 8'h00, 8'h00, "R10 seed");
        issue(3'd3, 8'h80, 8'h00, 3'd7, 8'h00, 8'h00, 8'h00, "R10 set bit7");
        issue(3'd4, 8'h80, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R10 clear bit0");
        issue(3'd1, 8'h80, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R10 readback");
        issue(3'd3, 8'h02, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h02, "R10 set bank2");
        issue(3'd1, 8'h02, 8'h00, 3'd0, 8'h00, 8'hFF, 8'h02, "R10 bank2 readback");
        issue(3'd1, 8'hFF, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R10 bank0 untouched");

        // R11 bit operations on registers
        issue(3'd2, 8'h07, 8'hFF, 3'd0, 8'h00, 8'h00, 8'h00, "R11 seed");
        issue(3'd4, 8'h07, 8'h00, 3'd5, 8'h00, 8'h00, 8'h00, "R11 clear bit5");
        issue(3'd3, 8'h02, 8'h00, 3'd3, 8'h00, 8'h05, 8'h02, "R11 set via ptr1");
        issue(3'd1, 8'h07, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R11 readback 07");
        issue(3'd1, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R11 readback 05");

        // R12 unused op codes
        issue(3'd5, 8'h80, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R12 op5");
        issue(3'd6, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R12 op6");
        issue(3'd7, 8'h02, 8'h00, 3'd1, 8'h00, 8'h50, 8'h02, "R12 op7");
        issue(3'd1, 8'h80, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R12 ram unchanged");
        issue(3'd1, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, "R12 sfr unchanged");

        idle(3);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule